// File: doc/BRIEF.md
# Write Channel Joiner with Byte-Lane Normaliser

This block is the front end of a write-accepting target on an AXI4 bus. It takes the write-address channel and the write-data channel on two independent paths, each into its own small queue. Data beats may therefore arrive well before the address they belong to. A joining state machine takes the oldest queued address, draws exactly that burst's beat count from the data queue in arrival order, and hands each beat downstream on a valid/ready stream. The final beat of each burst carries a last flag. The machine then raises a one-cycle response-request pulse.

Each beat leaves with the byte address computed for it. When the lane-steering input is high, a narrow beat is also rotated down so that its operand starts at byte lane 0. The data moves right by eight bits per byte of offset, and the strobe moves right by one bit per byte. The offset is the beat address modulo the strobe width. The beat address follows the burst type:
- Fixed: the start address for every beat.
- Incrementing: the start address for beat 0, then the size-aligned start plus the beat index times the transfer size.
- Wrapping: as incrementing, but folded into a window of (length+1) × size bytes.

The steering setting is latched when a burst starts.

The state machine has three states:
- `ST_IDLE` waits for a queued address. Transition *load*: on a non-empty address queue it pops the address and moves to `ST_STREAM`.
- `ST_STREAM` presents beats while the data queue holds one. Transition *final beat*: when the last beat's handshake completes it moves to `ST_RESP`.
- `ST_RESP` raises the response pulse for one cycle. Transition *retire*: it returns to `ST_IDLE` unconditionally.

Top module: `wrj_top`

## Requirements
- R1: `aw_ready` and `w_ready` are low whenever `rst_n` is low or `wake` is low.
- R2: A channel's ready output is low while its queue is full. The address queue holds `AWQ_DEPTH` entries (default 4), beyond the one the state machine holds, and the data queue holds `WQ_DEPTH` entries (default 8).
- R3: Data beats are accepted while no address is queued. No beat is presented on the output until an address for it has been accepted.
- R4: Each address passes exactly `aw_len`+1 beats to the output. `out_last` is 1 on the final one and 0 on the others. `out_valid` is low in the cycle of the response pulse.
- R5: Bursts leave in the order their addresses were accepted, and beats leave in the order they were accepted.
- R6: With steering off at burst start, `out_data` and `out_strb` equal the accepted beat unchanged.
- R7: With steering on, the output is the accepted beat shifted right by 8×off bits (data) and off bits (strobe), where off = `out_addr` mod strobe width. For an incrementing burst (`aw_burst`=1, and the reserved value 3), `out_addr` is the start address for beat 0 and aligned start + i×2^`aw_size` after that.
- R8: For a fixed burst (`aw_burst`=0), every beat's `out_addr`, and so its offset, equals the start address.
- R9: For a wrapping burst (`aw_burst`=2), beat addresses after beat 0 wrap inside the aligned window of (`aw_len`+1)×2^`aw_size` bytes.
- R10: `rsp_push` is high for exactly one cycle, in the cycle after the final beat's handshake.
- R11: During reset, `out_valid`, `rsp_push`, `aw_ready` and `w_ready` are all 0.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_strb`, `out_last` and `out_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake | input | 1 | Channel enable; low forces both ready outputs low |
| steer_en | input | 1 | Lane steering enable, latched at burst start |
| aw_valid | input | 1 | Address valid |
| aw_ready | output | 1 | Address ready |
| aw_addr | input | ADDR_W | Burst start byte address |
| aw_len | input | LEN_W | Beats in burst minus one |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping |
| w_valid | input | 1 | Data beat valid |
| w_ready | output | 1 | Data beat ready |
| w_data | input | DATA_W | Beat data |
| w_strb | input | DATA_W/8 | Beat byte strobes |
| out_valid | output | 1 | Joined beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_addr | output | ADDR_W | Byte address of this beat |
| out_data | output | DATA_W | Beat data, lane-normalised when steering |
| out_strb | output | DATA_W/8 | Beat strobes, lane-normalised when steering |
| out_last | output | 1 | Final beat of the burst |
| rsp_push | output | 1 | One-cycle write-response request |

## Verification
A beat counter that drifts from the burst length shows at once at the ports. `out_last` lands on the wrong beat, and on the next burst every data word appears one or more positions off, so the first mismatch is seen within a burst. A wrong offset or wrap mask corrupts `out_addr` on the first beat after beat 0 and shifts the data and strobes visibly on that same beat. A queue pointer error shows as a ready output that drops early or late against a counted fill, or as duplicated or skipped data words in the output stream.

// File: rtl/wrj_pkg.sv
package wrj_pkg;
    typedef enum logic [1:0] {
        BT_FIXED = 2'd0,
        BT_INCR  = 2'd1,
        BT_WRAP  = 2'd2,
        BT_RSVD  = 2'd3
    } burst_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_RESP   = 2'd2
    } join_st_e;
endpackage

// File: rtl/wrj_fifo.sv
module wrj_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  wp_q, rp_q;

    assign empty = (wp_q == rp_q);
    assign full  = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
    assign dout  = mem[rp_q[PW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push && !full) wp_q <= wp_q + 1'b1;
            if (pop && !empty) rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp_q[PW-1:0]] <= din;
    end
endmodule

// File: rtl/wrj_lane_calc.sv
module wrj_lane_calc #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [LEN_W-1:0]  len,
    input  logic [2:0]        size,
    input  wrj_pkg::burst_e   burst,
    input  logic [LEN_W-1:0]  idx,
    output logic [ADDR_W-1:0] beat_addr
);
    import wrj_pkg::*;

    logic [ADDR_W-1:0] step, lo_mask, aligned, linear;
    logic [ADDR_W-1:0] span, span_mask, win_base, wrapped;

    always_comb begin
        step      = {{(ADDR_W-1){1'b0}}, 1'b1} << size;
        lo_mask   = step - 1'b1;
        aligned   = start & ~lo_mask;
        linear    = aligned + (ADDR_W'(idx) << size);
        span      = (ADDR_W'(len) + 1'b1) << size;
        span_mask = span - 1'b1;
        win_base  = aligned & ~span_mask;
        wrapped   = win_base | (linear & span_mask);
        unique case (burst)
            BT_FIXED: beat_addr = start;
            BT_WRAP:  beat_addr = (idx == '0) ? start : wrapped;
            default:  beat_addr = (idx == '0) ? start : linear;
        endcase
    end
endmodule

// File: rtl/wrj_deshift.sv
module wrj_deshift #(
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8,
    parameter int OFF_W  = 2
) (
    input  logic              en,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] data_in,
    input  logic [STRB_W-1:0] strb_in,
    output logic [DATA_W-1:0] data_out,
    output logic [STRB_W-1:0] strb_out
);
    generate
        if (STRB_W > 1) begin : g_rotate
            always_comb begin
                if (en) begin
                    data_out = data_in >> {off, 3'b000};
                    strb_out = strb_in >> off;
                end else begin
                    data_out = data_in;
                    strb_out = strb_in;
                end
            end
        end else begin : g_pass
            logic unused_sel;
            assign unused_sel = en ^ (^off);
            assign data_out   = data_in;
            assign strb_out   = strb_in;
        end
    endgenerate
endmodule

// File: rtl/wrj_top.sv
module wrj_top #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 8,
    parameter int AWQ_DEPTH = 4,
    parameter int WQ_DEPTH  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wake,
    input  logic                  steer_en,
    input  logic                  aw_valid,
    output logic                  aw_ready,
    input  logic [ADDR_W-1:0]     aw_addr,
    input  logic [LEN_W-1:0]      aw_len,
    input  logic [2:0]            aw_size,
    input  logic [1:0]            aw_burst,
    input  logic                  w_valid,
    output logic                  w_ready,
    input  logic [DATA_W-1:0]     w_data,
    input  logic [DATA_W/8-1:0]   w_strb,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [ADDR_W-1:0]     out_addr,
    output logic [DATA_W-1:0]     out_data,
    output logic [DATA_W/8-1:0]   out_strb,
    output logic                  out_last,
    output logic                  rsp_push
);
    import wrj_pkg::*;

    localparam int STRB_W  = DATA_W / 8;
    localparam int OFF_W   = (STRB_W > 1) ? $clog2(STRB_W) : 1;
    localparam int AWREC_W = ADDR_W + LEN_W + 3 + 2;
    localparam int WREC_W  = DATA_W + STRB_W;

    // queue side
    logic               aw_full, aw_empty, aw_pop;
    logic               w_full, w_empty, w_pop;
    logic [AWREC_W-1:0] aw_head;
    logic [WREC_W-1:0]  w_head;

    assign aw_ready = rst_n && wake && !aw_full;
    assign w_ready  = rst_n && wake && !w_full;

    wrj_fifo #(.W(AWREC_W), .DEPTH(AWQ_DEPTH)) u_awq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (aw_valid && aw_ready),
        .din   ({aw_addr, aw_len, aw_size, aw_burst}),
        .pop   (aw_pop),
        .dout  (aw_head),
        .full  (aw_full),
        .empty (aw_empty)
    );

    wrj_fifo #(.W(WREC_W), .DEPTH(WQ_DEPTH)) u_wq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (w_valid && w_ready),
        .din   ({w_data, w_strb}),
        .pop   (w_pop),
        .dout  (w_head),
        .full  (w_full),
        .empty (w_empty)
    );

    // current burst context
    join_st_e          state_q, state_d;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LEN_W-1:0]  cur_len_q, beat_q;
    logic [2:0]        cur_size_q;
    burst_e            cur_burst_q;
    logic              cur_steer_q;
    logic              final_beat, fire;

    assign final_beat = (beat_q == cur_len_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!aw_empty) state_d = ST_STREAM;
            ST_STREAM: if (fire && final_beat) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        aw_pop    = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        rsp_push  = 1'b0;
        unique case (state_q)
            ST_IDLE:   aw_pop = !aw_empty;
            ST_STREAM: begin
                out_valid = !w_empty;
                out_last  = final_beat;
            end
            ST_RESP:   rsp_push = 1'b1;
            default:   ;
        endcase
    end

    assign fire  = out_valid && out_ready;
    assign w_pop = fire;

    // burst context and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q  <= '0;
            cur_len_q   <= '0;
            cur_size_q  <= '0;
            cur_burst_q <= BT_INCR;
            cur_steer_q <= 1'b0;
            beat_q      <= '0;
        end else if (aw_pop) begin
            {cur_addr_q, cur_len_q, cur_size_q} <= aw_head[AWREC_W-1:2];
            cur_burst_q <= burst_e'(aw_head[1:0]);
            cur_steer_q <= steer_en;
            beat_q      <= '0;
        end else if (fire) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // lane address and de-shift
    wrj_lane_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_calc (
        .start     (cur_addr_q),
        .len       (cur_len_q),
        .size      (cur_size_q),
        .burst     (cur_burst_q),
        .idx       (beat_q),
        .beat_addr (out_addr)
    );

    wrj_deshift #(.DATA_W(DATA_W), .STRB_W(STRB_W), .OFF_W(OFF_W)) u_shift (
        .en       (cur_steer_q),
        .off      (out_addr[OFF_W-1:0]),
        .data_in  (w_head[WREC_W-1:STRB_W]),
        .strb_in  (w_head[STRB_W-1:0]),
        .data_out (out_data),
        .strb_out (out_strb)
    );
endmodule

// File: rtl/wrj_checker.sv
module wrj_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int STRB_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wake,
    input logic              aw_ready,
    input logic              w_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data,
    input logic [STRB_W-1:0] out_strb,
    input logic              rsp_push
);
    // R1
    p_ready_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wake |-> (!aw_ready && !w_ready));

    // R11
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r11: assert (!aw_ready && !w_ready && !out_valid && !rsp_push);
        end
    end

    // R12
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
        $stable(out_strb) && $stable(out_last) && $stable(out_addr)));

    // R10
    p_resp_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> rsp_push);

    p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_push |=> !rsp_push);

    // R4
    p_no_beat_in_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_push |-> !out_valid);
endmodule

bind wrj_top wrj_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake      (wake),
    .aw_ready  (aw_ready),
    .w_ready   (w_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .out_strb  (out_strb),
    .rsp_push  (rsp_push)
);

// File: tb/wrj_top_tb_top.sv
module wrj_top_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int STRB_W = 4;
    localparam int LEN_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake = 1'b0;
    logic steer_en = 1'b0;
    logic aw_valid = 1'b0;
    logic [ADDR_W-1:0] aw_addr = '0;
    logic [LEN_W-1:0]  aw_len = '0;
    logic [2:0]        aw_size = '0;
    logic [1:0]        aw_burst = '0;
    logic w_valid = 1'b0;
    logic [DATA_W-1:0] w_data = '0;
    logic [STRB_W-1:0] w_strb = '0;
    logic out_ready = 1'b0;
    logic aw_ready, w_ready, out_valid, out_last, rsp_push;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;
    logic [STRB_W-1:0] out_strb;

    always #2 clk = ~clk;

    wrj_top dut_i (
        .clk(clk), .rst_n(rst_n), .wake(wake), .steer_en(steer_en),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_data(out_data), .out_strb(out_strb), .out_last(out_last),
        .rsp_push(rsp_push)
    );

    int checks = 0;
    int fails  = 0;

    int unsigned b_addr [256];
    int unsigned b_len  [256];
    int unsigned b_size [256];
    int unsigned b_type [256];
    bit          b_steer[256];
    logic [DATA_W-1:0] wd [2048];
    logic [STRB_W-1:0] ws [2048];
    int n_aw = 0, n_w = 0;
    int c_burst = 0, c_beat = 0, c_w = 0;
    int ready_mode = 0;  // 0 low, 1 high, 2 random
    bit last_prev = 0;
    bit hold_v = 0;
    logic [DATA_W-1:0] hold_d;
    logic [ADDR_W-1:0] hold_a;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected beat address from the burst rules
    function automatic int unsigned exp_addr(int unsigned a, int unsigned len,
                                             int unsigned sz, int unsigned bt, int unsigned i);
        int unsigned bytes, al, total, base;
        bytes = 1 << sz;
        al    = (a / bytes) * bytes;
        if (bt == 0 || i == 0) return a % 65536;
        if (bt == 2) begin
            total = (len + 1) * bytes;
            base  = (al / total) * total;
            return (base + ((al - base) + i * bytes) % total) % 65536;
        end
        return (al + i * bytes) % 65536;
    endfunction

    // consumer and output checker
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_push || last_prev)
                check(rsp_push == last_prev, "R10 rsp_push", rsp_push, last_prev);
            last_prev = 0;
            if (hold_v)
                check(out_valid && out_data == hold_d && out_addr == hold_a,
                      "R12 hold", out_data, hold_d);
            case (ready_mode)
                0: out_ready = 1'b0;
                1: out_ready = 1'b1;
                default: out_ready = ($urandom % 3) != 0;
            endcase
            if (out_valid && out_ready) begin
                int unsigned ea, off;
                logic [DATA_W-1:0] ed;
                logic [STRB_W-1:0] es;
                string tag;
                ea  = exp_addr(b_addr[c_burst], b_len[c_burst], b_size[c_burst],
                               b_type[c_burst], c_beat);
                off = ea % STRB_W;
                ed  = b_steer[c_burst] ? (wd[c_w] >> (8 * off)) : wd[c_w];
                es  = b_steer[c_burst] ? (ws[c_w] >> off) : ws[c_w];
                if (!b_steer[c_burst])      tag = "R6 data";
                else if (b_type[c_burst]==0) tag = "R8 data";
                else if (b_type[c_burst]==2) tag = "R9 data";
                else                         tag = "R7 data";
                check(out_data == ed && out_strb == es, tag, {out_strb, out_data}, {es, ed});
                check(out_addr == ADDR_W'(ea), "R7 addr", out_addr, ea);
                check(out_last == (c_beat == int'(b_len[c_burst])), "R4 last",
                      out_last, c_beat == int'(b_len[c_burst]));
                c_w++;
                if (c_beat == int'(b_len[c_burst])) begin
                    c_beat = 0; c_burst++; last_prev = 1;
                end else c_beat++;
            end
            hold_v = out_valid && !out_ready;
            hold_d = out_data;
            hold_a = out_addr;
        end
    end

    task automatic send_aw(input int unsigned a, input int unsigned len,
                           input int unsigned sz, input int unsigned bt);
        b_addr[n_aw] = a; b_len[n_aw] = len; b_size[n_aw] = sz;
        b_type[n_aw] = bt; b_steer[n_aw] = steer_en; n_aw++;
        @(negedge clk);
        aw_addr = ADDR_W'(a); aw_len = LEN_W'(len); aw_size = 3'(sz); aw_burst = 2'(bt);
        aw_valid = 1'b1;
        while (!aw_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        aw_valid = 1'b0;
    endtask

    task automatic send_w(input logic [DATA_W-1:0] d, input logic [STRB_W-1:0] s);
        wd[n_w] = d; ws[n_w] = s; n_w++;
        @(negedge clk);
        w_data = d; w_strb = s; w_valid = 1'b1;
        while (!w_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        w_valid = 1'b0;
    endtask

    task automatic drain();
        while (c_w != n_w || c_burst != n_aw) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        // reset state, R11 and R1
        repeat (3) @(negedge clk);
        check(!aw_ready && !w_ready, "R1 ready in reset", {aw_ready, w_ready}, 0);
        check(!out_valid && !rsp_push, "R11 quiet in reset", {out_valid, rsp_push}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!aw_ready && !w_ready, "R1 ready with wake low", {aw_ready, w_ready}, 0);
        wake = 1'b1;
        @(negedge clk);
        check(aw_ready && w_ready, "R1 ready after wake", {aw_ready, w_ready}, 3);

        // data ahead of address, R3
        ready_mode = 1;
        send_w(32'h1111_0001, 4'hF);
        send_w(32'h2222_0002, 4'hF);
        send_w(32'h3333_0003, 4'h3);
        repeat (3) @(negedge clk);
        check(!out_valid, "R3 no beat before address", out_valid, 0);
        send_aw(32'h40, 2, 2, 1);
        drain();

        // data queue full, R2
        ready_mode = 0;
        for (int i = 0; i < 8; i++) send_w(32'hA000_0000 + i, 4'hF);
        check(!w_ready, "R2 data queue full", w_ready, 0);
        send_aw(32'h80, 7, 2, 1);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) send_aw(32'h100 + 4 * i, 0, 2, 1);
        check(!aw_ready, "R2 address queue full", aw_ready, 0);
        ready_mode = 2;
        for (int i = 0; i < 4; i++) send_w(32'hB000_0000 + i, 4'h5);
        drain();
        check(c_burst == n_aw, "R5 burst order complete", c_burst, n_aw);

        // directed steering cases, R7 R8 R9
        steer_en = 1'b1;
        ready_mode = 1;
        send_aw(32'h1, 3, 0, 1);
        send_aw(32'h3, 2, 0, 0);
        send_aw(32'h6, 3, 0, 2);
        send_aw(32'h2, 2, 1, 1);
        for (int i = 0; i < 14; i++) send_w(32'h8877_6655 ^ (i << 24), 4'hF);
        drain();

        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            int unsigned rl[12], rs[12], rb[12], ra[12];
            int tot;
            steer_en = ph[0];
            ready_mode = 2;
            tot = 0;
            for (int k = 0; k < 12; k++) begin
                rb[k] = $urandom % 3;
                rs[k] = $urandom % 3;
                if (rb[k] == 2) begin
                    int unsigned sel;
                    sel = $urandom % 3;
                    rl[k] = (sel == 0) ? 1 : (sel == 1) ? 3 : 7;
                end else rl[k] = $urandom % 8;
                ra[k] = $urandom % 65536;
                if (rb[k] == 2) ra[k] = ra[k] & ~((1 << rs[k]) - 1);
                tot += rl[k] + 1;
            end
            fork
                begin
                    repeat ($urandom % 10) @(negedge clk);
                    for (int k = 0; k < 12; k++) begin
                        send_aw(ra[k], rl[k], rs[k], rb[k]);
                        repeat ($urandom % 4) @(negedge clk);
                    end
                end
                begin
                    for (int j = 0; j < tot; j++) begin
                        send_w($urandom, 4'($urandom));
                        if (($urandom % 4) == 0) @(negedge clk);
                    end
                end
            join
            drain();
            check(c_burst == n_aw && c_w == n_w, "R5 bursts retired in order", c_burst, n_aw);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule